// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Takeover

This block controls eight general-purpose pins from a small register bus. Software sets each pin's direction through a direction register and loads an output latch through a data register. A pin whose direction bit is 1 drives the latch bit onto its pad. A pin whose direction bit is 0 has its driver turned off, so the pad floats.

Any pin can be handed to an on-chip peripheral at any time. When the peripheral raises that pin's enable, the pad is driven with the peripheral's value instead of the latch, whatever the direction bit says. Pad levels pass through a two-stage synchronizer. The synchronized levels are returned when software reads the data register, and they are also forwarded to the peripherals as their input bus.

Reset clears the direction register, which makes every pin a floating input. Reset leaves the output latch alone. Software is expected to load the latch first and then turn on the driver, so that no stale value reaches the pin.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted (rst_n low) and afterwards until a direction write, every direction bit is 0 and every pad_oe bit is 0, unless the peripheral enable for that pin is raised.
- R2: A pin with direction bit 1 and per_oe 0 has pad_oe 1 and drives pad_out equal to its latch bit.
- R3: A pin with direction bit 0 and per_oe 0 has pad_oe 0.
- R4: A bus write to address 0 loads the latch whatever the direction bits are. The stored value appears on pad_out once the direction bit is set.
- R5: A read at address 0 returns the pad_in levels as they were two clock edges earlier, and never the latch contents.
- R6: When per_oe is 1 for a pin, that pin has pad_oe 1 and pad_out equal to per_out, regardless of its direction bit.
- R7: per_in carries the same synchronized pad levels as an address 0 read, with the same two-edge latency.
- R8: Reset does not change the output latch.
- R9: A bus write to address 1 loads the direction register, and a read at address 1 returns it.
- R10: Reads at addresses 2 and 3 return 0. Writes to them change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address (0 = data, 1 = direction) |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Level sensed at each pad |
| pad_out | output | 8 | Value driven at each pad |
| pad_oe | output | 8 | Pad driver enable, 1 = drive |
| per_oe | input | 8 | Per-pin peripheral takeover enable |
| per_out | input | 8 | Peripheral output value per pin |
| per_in | output | 8 | Synchronized pad levels forwarded to peripherals |

## Verification
The bench models the pads: a driven pin reads back pad_out, and a floating pin reads back an independent external value. This lets a read tell the live level apart from the latch. A sweep over all 256 latch values with every driver on checks the output path. Pseudo-random mixtures of direction, latch, takeover enable, peripheral value and external level separate the three sources a pin can take (latch, peripheral, outside world). Directed sequences check the reset-versus-latch ordering, the exact two-edge synchronizer latency, and the unmapped addresses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1
  } reg_sel_e;

  // pad output enable for one pin: takeover wins, else direction bit
  function automatic logic pin_oe(input logic dir_b, input logic take_b);
    return dir_b | take_b;
  endfunction

  // pad output value for one pin
  function automatic logic pin_val(input logic latch_b, input logic take_b,
                                   input logic per_b);
    return take_b ? per_b : latch_b;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    sync_q <= meta_q;
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      level,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      latch,
  output logic [W-1:0]      dir
);
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic         wr_data;
  logic         wr_dir;

  assign wr_data = wr && (addr == SEL_DATA);
  assign wr_dir  = wr && (addr == SEL_DIR);

  // output latch: no reset term on purpose
  always_ff @(posedge clk) begin
    if (wr_data) latch_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= wdata;
  end

  always_comb begin
    case (addr)
      SEL_DATA: rdata = level;
      SEL_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

  assign latch = latch_q;
  assign dir   = dir_q;

  assert_dir_reset_R1: assert property (@(posedge clk)
    !rst_n |=> dir_q == '0);
  assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> latch_q == $past(wdata));
  assert_dir_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > SEL_DIR) |-> rdata == '0);
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] latch,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] take,
  input  logic [W-1:0] per_val,
  output logic [W-1:0] oe,
  output logic [W-1:0] val
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign oe[i]  = pin_oe(dir[i], take[i]);
    assign val[i] = pin_val(latch[i], take[i], per_val[i]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      per_oe,
  input  logic [W-1:0]      per_out,
  output logic [W-1:0]      per_in
);
  logic [W-1:0] level;
  logic [W-1:0] latch;
  logic [W-1:0] dir;
  logic [1:0]   warm_q;   // edges since reset, saturating, for checks

  gpio_sync #(.W(W)) u_sync (
    .clk (clk),
    .d   (pad_in),
    .q   (level)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .level (level),
    .rdata (bus_rdata),
    .latch (latch),
    .dir   (dir)
  );

  gpio_pinmux #(.W(W)) u_mux (
    .latch   (latch),
    .dir     (dir),
    .take    (per_oe),
    .per_val (per_out),
    .oe      (pad_oe),
    .val     (pad_out)
  );

  assign per_in = level;

  always_ff @(posedge clk) begin
    if (!rst_n)            warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_takeover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & per_oe) == per_oe) && ((pad_out & per_oe) == (per_out & per_oe)));
  assert_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir & ~per_oe) == '0);
  assert_sync_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> per_in == $past(pad_in, 2));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pad_in, pad_out, pad_oe, per_in;
  logic [7:0] per_oe = '0, per_out = '0, ext = '0;
  int total = 0, bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  // pad model: driven pins read back their own value
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_oe(per_oe),
    .per_out(per_out), .per_in(per_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  function automatic logic [7:0] nxt();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=00 exp=01");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, dv, lv, po, pv, e, eoe, eout, pin;
    cyc(3);
    chk("R1 oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 oe after reset", pad_oe, 8'h00);
    rd(2'd1, v); chk("R1 dir after reset", v, 8'h00);

    // latch loaded while pins float
    wr(2'd0, 8'hA5);
    chk("R3 still floating", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    chk("R2 drive on", pad_oe, 8'hFF);
    chk("R4 latch shows", pad_out, 8'hA5);
    rd(2'd1, v); chk("R9 dir readback", v, 8'hFF);

    // full latch sweep with all drivers on
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, d[7:0]);
      chk("R2 sweep out", pad_out, d[7:0]);
      cyc(2);
      rd(2'd0, v); chk("R5 sweep level", v, d[7:0]);
    end

    // exact synchronizer latency on floating pins
    wr(2'd1, 8'h00);
    ext = 8'h0F; cyc(3);
    ext = 8'hF0;
    cyc(1);
    chk("R7 one edge old", per_in, 8'h0F);
    rd(2'd0, v); chk("R5 one edge old", v, 8'h0F);
    cyc(1);
    chk("R7 two edges new", per_in, 8'hF0);
    rd(2'd0, v); chk("R5 two edges new", v, 8'hF0);

    // mixed sources
    for (int k = 0; k < 300; k++) begin
      dv = nxt(); lv = nxt(); po = nxt(); pv = nxt(); e = nxt();
      per_oe = po; per_out = pv; ext = e;
      wr(2'd0, lv);
      wr(2'd1, dv);
      cyc(2);
      eoe  = dv | po;
      eout = (po & pv) | (~po & lv);
      pin  = (eoe & eout) | (~eoe & e);
      chk("R2 R3 R6 oe", pad_oe, eoe);
      chk("R2 R6 out", pad_out & eoe, eout & eoe);
      rd(2'd0, v); chk("R5 live level", v, pin);
      chk("R7 per_in", per_in, pin);
    end
    per_oe = 8'h00;

    // latch survives reset
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    chk("R1 reset floats", pad_oe, 8'h00);
    rst_n = 1'b1;
    wr(2'd1, 8'hFF);
    chk("R8 latch kept", pad_out, 8'h3C);

    // unmapped addresses
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd2, v); chk("R10 read a2", v, 8'h00);
    rd(2'd3, v); chk("R10 read a3", v, 8'h00);
    rd(2'd1, v); chk("R10 dir untouched", v, 8'hFF);
    chk("R10 latch untouched", pad_out, 8'h3C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule